// File: doc/BRIEF.md
# Region to Aligned Page Splitter

This engine turns one memory region into a sequence of translation pages. A region is offered as a virtual base, a physical base, a byte length and a set of attribute flags. The engine then walks the region and emits one page per handshake on a valid/ready stream. Each page carries its virtual base, its physical base, a 3-bit size code and the region's flags.

For every page, the engine picks the largest of eight supported sizes that fits. Both bases must be aligned to that size, and the remaining length must cover it. The supported sizes run from 4 KiB up to 16 GiB. The choice is made combinationally from the current state, so with the consumer always ready one page leaves per cycle.

The walk ends with a one-cycle completion pulse that reports the number of pages emitted. The same pulse can carry an error flag. There are two error cases: no size fits while length remains, or the configured page budget runs out first.

Top module: `region_page_splitter`

## Requirements
- R1: The size code maps 0→4 KiB, 1→16 KiB, 2→64 KiB, 3→2 MiB, 4→32 MiB, 5→512 MiB, 6→1 GiB, 7→16 GiB. Each emitted page uses the largest code that qualifies.
- R2: A code qualifies only if the current virtual base and the current physical base are both multiples of its size, and the remaining length is at least that size.
- R3: After each accepted page, both bases grow by the page size and the remaining length shrinks by it. Consecutive pages are therefore contiguous in both address spaces.
- R4: When the remaining length reaches zero, `done` pulses for one cycle and `done_count` equals the number of pages emitted, with both error flags low.
- R5: If length remains but no size qualifies (a base not 4 KiB aligned, or less than 4 KiB left), the walk stops. `done` pulses with `err_align` high and `done_count` equal to the pages emitted so far.
- R6: If MAX_PAGES pages have been emitted and length remains, the walk stops. `done` pulses with `err_cap` high and `done_count` equal to MAX_PAGES. At most one error flag is ever high, and only together with `done`.
- R7: Every page carries the region's flags unchanged.
- R8: While `pg_valid` is high and `pg_ready` is low, the page outputs hold steady. With `pg_ready` held high, pages are accepted on consecutive cycles.
- R9: A region is accepted only while `start_ready` is high, which happens only when the engine is idle. An offer made while busy has no effect on the pages. A zero-length region completes with a count of zero and emits no page.
- R10: During and after reset, `start_ready` is high and `pg_valid`, `done` and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Region offer |
| start_ready | output | 1 | Engine idle, region may be taken |
| start_virt | input | ADDR_W | Region virtual base |
| start_phys | input | ADDR_W | Region physical base |
| start_len | input | LEN_W | Region length in bytes |
| start_flags | input | FLAG_W | Region attribute flags |
| pg_valid | output | 1 | Page available |
| pg_ready | input | 1 | Consumer takes page |
| pg_virt | output | ADDR_W | Page virtual base |
| pg_phys | output | ADDR_W | Page physical base |
| pg_code | output | 3 | Page size code |
| pg_flags | output | FLAG_W | Page attribute flags |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | CNT_W | Pages emitted for the region |
| err_align | output | 1 | No size qualified (with done) |
| err_cap | output | 1 | Page budget exhausted (with done) |

## Verification
The assertions take two things for granted about the inputs. First, the consumer never withdraws a page: once `pg_valid` is high, the only thing that changes the page is a handshake. Second, a new region is offered only through the start handshake. The stimulus lowers `start_valid` on the falling edge right after the region is taken, or right after `done`. Some regions keep offering unrelated values while the engine is busy, to show that such offers are ignored. Ready patterns of always, every second cycle and every third cycle exercise the hold rule. All addresses stay below 2^36, so the 48-bit sums never wrap.

// File: rtl/region_page_splitter.sv
module region_page_splitter #(
  parameter int ADDR_W    = 48,
  parameter int LEN_W     = 48,
  parameter int FLAG_W    = 16,
  parameter int MAX_PAGES = 64,
  localparam int CNT_W    = $clog2(MAX_PAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_virt,
  input  logic [ADDR_W-1:0] start_phys,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [FLAG_W-1:0] start_flags,
  output logic              pg_valid,
  input  logic              pg_ready,
  output logic [ADDR_W-1:0] pg_virt,
  output logic [ADDR_W-1:0] pg_phys,
  output logic [2:0]        pg_code,
  output logic [FLAG_W-1:0] pg_flags,
  output logic              done,
  output logic [CNT_W-1:0]  done_count,
  output logic              err_align,
  output logic              err_cap
);

  function automatic logic [5:0] code_shift(input logic [2:0] c);
    case (c)
      3'd0: code_shift = 6'd12;
      3'd1: code_shift = 6'd14;
      3'd2: code_shift = 6'd16;
      3'd3: code_shift = 6'd21;
      3'd4: code_shift = 6'd25;
      3'd5: code_shift = 6'd29;
      3'd6: code_shift = 6'd30;
      default: code_shift = 6'd34;
    endcase
  endfunction

  logic              busy;
  logic [ADDR_W-1:0] va, pa;
  logic [LEN_W-1:0]  rem;
  logic [FLAG_W-1:0] flg;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        fits;
  logic [2:0]        code;
  logic [5:0]        sh;
  logic [ADDR_W-1:0] step_a;
  logic [LEN_W-1:0]  step_l;
  logic              any_fit, at_cap, rem_nz, fire, finish;

  for (genvar g = 0; g < 8; g++) begin : g_size
    localparam int SH = int'(code_shift(3'(g)));
    assign fits[g] = (va[SH-1:0] == '0) && (pa[SH-1:0] == '0) && (|rem[LEN_W-1:SH]);
  end

  always_comb begin
    code = 3'd0;
    for (int i = 0; i < 8; i++)
      if (fits[i]) code = 3'(i);
  end

  assign sh      = code_shift(code);
  assign step_a  = ADDR_W'(1) << sh;
  assign step_l  = LEN_W'(1) << sh;
  assign any_fit = |fits;
  assign rem_nz  = |rem;
  assign at_cap  = (cnt == CNT_W'(MAX_PAGES));

  assign start_ready = !busy;
  assign pg_valid    = busy && rem_nz && !at_cap && any_fit;
  assign fire        = pg_valid && pg_ready;
  assign finish      = busy && !pg_valid;
  assign pg_virt     = va;
  assign pg_phys     = pa;
  assign pg_code     = code;
  assign pg_flags    = flg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      va         <= '0;
      pa         <= '0;
      rem        <= '0;
      flg        <= '0;
      cnt        <= '0;
      done       <= 1'b0;
      done_count <= '0;
      err_align  <= 1'b0;
      err_cap    <= 1'b0;
    end else begin
      done      <= 1'b0;
      err_align <= 1'b0;
      err_cap   <= 1'b0;
      if (!busy) begin
        if (start_valid) begin
          busy <= 1'b1;
          va   <= start_virt;
          pa   <= start_phys;
          rem  <= start_len;
          flg  <= start_flags;
          cnt  <= '0;
        end
      end else if (fire) begin
        va  <= va + step_a;
        pa  <= pa + step_a;
        rem <= rem - step_l;
        cnt <= cnt + CNT_W'(1);
      end else if (finish) begin
        busy       <= 1'b0;
        done       <= 1'b1;
        done_count <= cnt;
        err_cap    <= rem_nz && at_cap;
        err_align  <= rem_nz && !at_cap;
      end
    end
  end

  logic [ADDR_W-1:0] pg_mask;
  assign pg_mask = (ADDR_W'(1) << code_shift(pg_code)) - ADDR_W'(1);

  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pg_valid |-> ((pg_virt & pg_mask) == '0) && ((pg_phys & pg_mask) == '0));

  assert_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && pg_ready) |=> !pg_valid ||
      (pg_virt == $past(pg_virt) + $past(pg_mask) + ADDR_W'(1)));

  assert_cap_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count <= CNT_W'(MAX_PAGES)));

  assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_align, err_cap}) && ((err_align || err_cap) -> done));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && !pg_ready) |=> pg_valid && $stable(pg_virt) && $stable(pg_phys)
      && $stable(pg_code) && $stable(pg_flags));

  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready && !done);

  assert_no_page_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !pg_valid);

endmodule

// File: tb/sim_region_page_splitter.sv
module sim_region_page_splitter;
  localparam int CAP = 8;
  localparam int CW  = $clog2(CAP + 1);
  localparam int NV  = 9;

  localparam logic [47:0] TV_V [NV] = '{48'h0, 48'h40000000, 48'h1000, 48'h10000, 48'h800,
                                       48'h0, 48'h7000, 48'h400000000, 48'h1F0000};
  localparam logic [47:0] TV_P [NV] = '{48'h0, 48'h80000000, 48'h1000, 48'h11000, 48'h800,
                                       48'h0, 48'h9000, 48'h800000000, 48'h3F0000};
  localparam logic [47:0] TV_L [NV] = '{48'h1000, 48'h40000000, 48'h5000, 48'h10000, 48'h1000,
                                       48'h1800, 48'h0, 48'h400001000, 48'h220000};
  localparam int TV_MODE [NV] = '{0, 1, 0, 2, 0, 1, 0, 2, 1};
  localparam int TV_ERR  [NV] = '{0, 0, 0, 2, 1, 1, 0, 0, 0};
  localparam bit TV_JUNK [NV] = '{0, 0, 1, 0, 0, 0, 1, 1, 0};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start_valid, start_ready, pg_valid, pg_ready, done, err_align, err_cap;
  logic [47:0] start_virt, start_phys, start_len, pg_virt, pg_phys;
  logic [15:0] start_flags, pg_flags;
  logic [2:0]  pg_code;
  logic [CW-1:0] done_count;

  int checks = 0;
  int fails  = 0;

  region_page_splitter #(.ADDR_W(48), .LEN_W(48), .FLAG_W(16), .MAX_PAGES(CAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_virt(start_virt), .start_phys(start_phys), .start_len(start_len),
    .start_flags(start_flags), .pg_valid(pg_valid), .pg_ready(pg_ready),
    .pg_virt(pg_virt), .pg_phys(pg_phys), .pg_code(pg_code), .pg_flags(pg_flags),
    .done(done), .done_count(done_count), .err_align(err_align), .err_cap(err_cap));

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned size_of(input int c);
    case (c)
      0: return 64'h1000;
      1: return 64'h4000;
      2: return 64'h10000;
      3: return 64'h200000;
      4: return 64'h2000000;
      5: return 64'h20000000;
      6: return 64'h40000000;
      default: return 64'h400000000;
    endcase
  endfunction

  function automatic int pick(input longint unsigned v, input longint unsigned p,
                              input longint unsigned r);
    for (int c = 7; c >= 0; c--)
      if (v % size_of(c) == 0 && p % size_of(c) == 0 && r >= size_of(c)) return c;
    return -1;
  endfunction

  task automatic run_vec(input longint unsigned v, input longint unsigned p,
                         input longint unsigned l, input logic [15:0] f,
                         input int mode, input int exp_err, input bit junk);
    longint unsigned mv = v, mp = p, mr = l;
    int mc = 0, cyc = 0, last = -10, ec, merr;
    bit held = 0, got = 0;
    logic [47:0] hv = '0, hp = '0;
    logic [2:0]  hc = '0;
    @(negedge clk);
    start_valid = 1'b1; start_virt = 48'(v); start_phys = 48'(p);
    start_len = 48'(l); start_flags = f;
    @(negedge clk);
    if (junk) begin
      start_virt = 48'h123000; start_phys = 48'h777000; start_len = 48'h3000; start_flags = 16'hDEAD;
    end else start_valid = 1'b0;
    while (!got && cyc < 3000) begin
      pg_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 2 == 0) : (cyc % 3 == 0);
      if (held)
        check(pg_valid && pg_virt == hv && pg_phys == hp && pg_code == hc,
              "R8", "page held while stalled", {pg_virt, pg_code}, {hv, hc});
      held = 0;
      if (done) begin
        got = 1; start_valid = 1'b0;
        merr = (mr == 0) ? 0 : (mc == CAP) ? 2 : 1;
        check(merr == exp_err, "R4", "table outcome vs model", merr, exp_err);
        check(done_count == CW'(mc), "R4", "done_count", done_count, mc);
        check(err_align == (merr == 1), "R5", "err_align", err_align, merr == 1);
        check(err_cap == (merr == 2), "R6", "err_cap", err_cap, merr == 2);
      end else if (pg_valid) begin
        ec = pick(mv, mp, mr);
        check(!start_ready, "R9", "start_ready low while busy", start_ready, 0);
        if (mr == 0 || mc >= CAP || ec < 0) begin
          check(0, "R6", "unexpected page", pg_virt, 0);
        end else begin
          check(pg_code == 3'(ec), "R1", "size code", pg_code, ec);
          check(pg_virt == 48'(mv) && pg_phys == 48'(mp), "R3", "page bases",
                {pg_virt, pg_phys}, {48'(mv), 48'(mp)});
          check(pg_virt % size_of(int'(pg_code)) == 0, "R2", "virt aligned", pg_virt, 0);
          check(pg_flags == f, "R7", "flags", pg_flags, f);
          if (pg_ready) begin
            if (mode == 0 && mc > 0) check(cyc == last + 1, "R8", "back-to-back", cyc, last + 1);
            last = cyc;
            mv += size_of(ec); mp += size_of(ec); mr -= size_of(ec); mc++;
          end else begin
            held = 1; hv = pg_virt; hp = pg_phys; hc = pg_code;
          end
        end
      end
      cyc++;
      @(negedge clk);
    end
    check(got, "R4", "done seen", got, 1);
    start_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_valid = 1'b0; pg_ready = 1'b1;
    start_virt = '0; start_phys = '0; start_len = '0; start_flags = '0;
    repeat (3) @(negedge clk);
    check(start_ready && !pg_valid && !done && !err_align && !err_cap, "R10", "reset state",
          {start_ready, pg_valid, done, err_align, err_cap}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(start_ready && !pg_valid && !done, "R10", "idle after reset",
          {start_ready, pg_valid, done}, 3'b100);
    for (int i = 0; i < NV; i++)
      run_vec(TV_V[i], TV_P[i], TV_L[i], 16'hA5A5 ^ 16'(i * 16'h111), TV_MODE[i], TV_ERR[i], TV_JUNK[i]);
    // R9: zero length gives count zero and no page
    @(negedge clk);
    start_valid = 1'b1; start_len = '0; start_virt = 48'h5000; start_phys = 48'h5000;
    @(negedge clk);
    start_valid = 1'b0;
    check(!pg_valid, "R9", "no page for zero length", pg_valid, 0);
    @(negedge clk);
    check(done && done_count == '0 && !err_align && !err_cap, "R9", "zero length done",
          {done, done_count}, {1'b1, CW'(0)});
    @(negedge clk);
    check(start_ready && !done, "R10", "idle again", {start_ready, done}, 2'b10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule